// File: doc/BRIEF.md
# Direct MMIO Range Decoder

The decoder holds a small set of independently programmed address windows. Each window sends a contiguous span of the system address space to one of several downstream PCI bridges. Every request presents a system address together with a flag that says whether a wider distributed window also claims it. One cycle later the decoder reports three things. It reports whether one of its direct windows matched, and if so which window and which bridge. It reports which of three targets owns the access: a direct window, the distributed window, or RAM. It also gives the 32-bit address to forward to the bridge.

Software programs each window through three registers on a single write port: a base, a size and a route. The base sets where the window starts and carries the enable bit. The size sets how long the window is, and the route picks the bridge. Both base and size are kept only to 1 MB granularity. The size is clamped to 64 MB. A base whose top nibble is all ones is moved to the top of the system address space.

Top module: `mmio_direct_decode`

## Requirements
- R1: Register index `wr_idx` addresses range `wr_idx / 3`. The field is chosen by `wr_idx % 3`: 0 is the base, 1 is the size, 2 is the route. A write with `wr_en` high is used by requests from the next cycle on. Indices at or above 3*NUM_RANGES change nothing.
- R2: Bit 0 of the base register enables its range. After reset every range is disabled, so no request hits.
- R3: The low 20 bits of the base register do not take part in the address compare, apart from enable bit 0.
- R4: The low 20 bits of the size register are ignored. A size above 64 MB (0x0400_0000) acts as exactly 64 MB. A size that is zero after truncation disables the range.
- R5: Bits [1:0] of the route register give the reported `bridge`. Higher route bits have no effect.
- R6: Base bits [31:0] are extended to the system width with all ones when base bits [31:28] equal 4'hF, and with zeros otherwise.
- R7: A range hits when extended base <= address < extended base + effective size. When several ranges hit, the lowest-numbered one is reported. With no hit, `hit_range` and `bridge` are 0.
- R8: Exactly one of `tgt_direct`, `tgt_window` and `tgt_ram` is set on each result. A direct hit wins over `win_hit`, and `win_hit` wins over RAM.
- R9: Each request with `req_valid` gives exactly one result with `out_valid` in the next cycle. Its `fwd_addr` equals the request address bits [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index (range*3 + field) |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | SYS_W | System address |
| win_hit | input | 1 | Distributed window claims the address |
| out_valid | output | 1 | Result strobe |
| hit | output | 1 | A direct range matched |
| hit_range | output | RW | Winning range number |
| bridge | output | BW | Selected bridge |
| fwd_addr | output | 32 | Address forwarded to the bridge |
| tgt_ram | output | 1 | Access goes to RAM |
| tgt_window | output | 1 | Access goes to the distributed window |
| tgt_direct | output | 1 | Access goes to a direct range |

## Verification
The bench builds the decoder with the default four ranges and four bridges. It narrows the system address to 40 bits, so that the extension of an all-ones top nibble lands on visibly distinct upper bits (0xFF) that a request can reach both with and without. With 1 MB granularity and the 64 MB clamp, both edges of each window can be hit with a few addresses. These edges are the last byte in the window and the first byte past it. Four ranges are enough to stack two over the same span and to show which one wins as the lower range is enabled and disabled.

// File: rtl/mmio_direct_decode.sv
module mmio_direct_decode #(
  parameter int NUM_RANGES  = 4,
  parameter int NUM_BRIDGES = 4,
  parameter int SYS_W       = 48,
  parameter int GRAN_SHIFT  = 20,
  parameter int CAP_SHIFT   = 26,
  localparam int IDX_W = $clog2(3 * NUM_RANGES),
  localparam int RW    = $clog2(NUM_RANGES),
  localparam int BW    = $clog2(NUM_BRIDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             req_valid,
  input  logic [SYS_W-1:0] req_addr,
  input  logic             win_hit,
  output logic             out_valid,
  output logic             hit,
  output logic [RW-1:0]    hit_range,
  output logic [BW-1:0]    bridge,
  output logic [31:0]      fwd_addr,
  output logic             tgt_ram,
  output logic             tgt_window,
  output logic             tgt_direct
);

  localparam int HI_W = SYS_W - 32;
  localparam logic [31:0] CAP = 32'(1) << CAP_SHIFT;
  localparam logic [31:0] GMASK = ~((32'(1) << GRAN_SHIFT) - 32'(1));

  logic [NUM_RANGES-1:0]         hv;
  logic [NUM_RANGES-1:0][BW-1:0] rbits;

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
    logic [31:0]      base_q, size_q, route_q;
    logic [31:0]      bt, st_raw, st;
    logic [SYS_W-1:0] bx;
    logic [SYS_W:0]   lim;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q  <= '0;
        size_q  <= '0;
        route_q <= '0;
      end else if (wr_en) begin
        if (wr_idx == IDX_W'(3*i))     base_q  <= wr_data;
        if (wr_idx == IDX_W'(3*i + 1)) size_q  <= wr_data;
        if (wr_idx == IDX_W'(3*i + 2)) route_q <= wr_data;
      end
    end

    assign bt     = base_q & GMASK;
    assign st_raw = size_q & GMASK;
    assign st     = (st_raw > CAP) ? CAP : st_raw;
    assign bx     = {{HI_W{bt[31:28] == 4'hF}}, bt};
    assign lim    = {1'b0, bx} + (SYS_W+1)'(st);
    assign hv[i]  = base_q[0] && (st != '0) && (req_addr >= bx) &&
                    ({1'b0, req_addr} < lim);
    assign rbits[i] = route_q[BW-1:0];
  end

  logic          hit_n;
  logic [RW-1:0] rng_n;
  logic [BW-1:0] br_n;

  always_comb begin
    hit_n = 1'b0;
    rng_n = '0;
    br_n  = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit_n = 1'b1;
        rng_n = RW'(i);
        br_n  = rbits[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      hit        <= 1'b0;
      hit_range  <= '0;
      bridge     <= '0;
      fwd_addr   <= '0;
      tgt_ram    <= 1'b0;
      tgt_window <= 1'b0;
      tgt_direct <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        hit        <= hit_n;
        hit_range  <= rng_n;
        bridge     <= br_n;
        fwd_addr   <= req_addr[31:0];
        tgt_direct <= hit_n;
        tgt_window <= !hit_n && win_hit;
        tgt_ram    <= !hit_n && !win_hit;
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({tgt_ram, tgt_window, tgt_direct}) == 1); // R8
  AST_DIRECT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && hit |-> tgt_direct && !tgt_window); // R8
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R9
  AST_FWD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> fwd_addr == $past(req_addr[31:0])); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !hit |-> hit_range == '0 && bridge == '0); // R7

endmodule

// File: tb/sim_mmio_direct_decode.sv
module sim_mmio_direct_decode;
  localparam int SYS_W = 40;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic req_valid = 0, win_hit = 0;
  logic [SYS_W-1:0] req_addr = 0;
  logic out_valid, hit, tgt_ram, tgt_window, tgt_direct;
  logic [1:0] hit_range, bridge;
  logic [31:0] fwd_addr;

  always #5 clk = ~clk;

  mmio_direct_decode #(.NUM_RANGES(N), .NUM_BRIDGES(4), .SYS_W(SYS_W)) u0 (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .req_valid, .req_addr, .win_hit,
    .out_valid, .hit, .hit_range, .bridge, .fwd_addr, .tgt_ram, .tgt_window,
    .tgt_direct);

  int checks = 0, errors = 0;
  logic [31:0] sb [N], ss [N], sr [N];
  logic [39:0] expq [$];
  string tagq [$];

  function automatic logic [39:0] model(logic [SYS_W-1:0] a, logic w);
    logic h = 0; logic [1:0] r = 0, b = 0;
    for (int i = N - 1; i >= 0; i--) begin
      logic [31:0] bt = sb[i] & 32'hFFF0_0000;
      logic [31:0] st = ss[i] & 32'hFFF0_0000;
      logic [SYS_W-1:0] bx;
      logic [SYS_W:0] top;
      if (st > 32'h0400_0000) st = 32'h0400_0000;
      bx = {(bt[31:28] == 4'hF) ? 8'hFF : 8'h00, bt};
      top = {1'b0, bx} + {9'b0, st};
      if (sb[i][0] && st != 0 && a >= bx && {1'b0, a} < top) begin
        h = 1; r = 2'(i); b = sr[i][1:0];
      end
    end
    return {h, r, b, h, !h && w, !h && !w, a[31:0]};
  endfunction

  task automatic wreg(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_data = d;
    if (idx < 3*N) begin
      if (idx % 3 == 0) sb[idx/3] = d;
      else if (idx % 3 == 1) ss[idx/3] = d;
      else sr[idx/3] = d;
    end
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic req(logic [SYS_W-1:0] a, logic w, string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; win_hit = w;
    expq.push_back(model(a, w)); tagq.push_back(tag);
    @(posedge clk); #1 req_valid = 0; win_hit = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [39:0] act, e; string t;
      act = {hit, hit_range, bridge, tgt_direct, tgt_window, tgt_ram, fwd_addr};
      checks++;
      if (expq.size() == 0) begin
        errors++; $display("FAIL R9 unexpected result act=%h exp=none", act);
      end else begin
        e = expq.pop_front(); t = tagq.pop_front();
        if (act !== e) begin
          errors++; $display("FAIL %s act=%h exp=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin sb[i] = 0; ss[i] = 0; sr[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R9 reset out_valid act=%b exp=0", out_valid); end
    rst_n = 1;
    req(40'h00_1000_0000, 0, "R2 reset miss");
    req(40'h00_0000_1234, 1, "R8 window over ram");
    wreg(0, 32'h1000_0001); wreg(1, 32'h0020_0000); wreg(2, 32'h1);
    req(40'h00_1000_0000, 0, "R7 low edge");
    req(40'h00_101F_FFFF, 1, "R8 direct over window, R7 last byte");
    req(40'h00_1020_0000, 0, "R7 past end");
    req(40'h00_0FFF_FFFF, 0, "R7 below base");
    wreg(0, 32'h1234_5679);
    req(40'h00_1230_0000, 0, "R3 base truncated");
    wreg(1, 32'h0023_4567);
    req(40'h00_1250_0000, 0, "R4 size truncated");
    req(40'h00_124F_FFFF, 0, "R4 last byte");
    wreg(1, 32'h1000_0000);
    req(40'h00_1630_0000 - 1, 0, "R4 cap last");
    req(40'h00_1630_0000, 0, "R4 cap end");
    wreg(1, 32'h000F_FFFF);
    req(40'h00_1230_0000, 0, "R4 zero size");
    wreg(1, 32'h0010_0000); wreg(2, 32'hFFFF_FFFE);
    req(40'h00_1230_0010, 0, "R5 route masked");
    wreg(3, 32'hF800_0001); wreg(4, 32'h0010_0000); wreg(5, 32'h3);
    req(40'hFF_F800_0010, 0, "R6 extended hit");
    req(40'h00_F800_0010, 0, "R6 unextended miss");
    wreg(6, 32'h7000_0001); wreg(7, 32'h0010_0000); wreg(8, 32'h2);
    req(40'h00_7000_0000, 0, "R6 plain hit");
    req(40'hFF_7000_0000, 0, "R6 plain no extend");
    wreg(9, 32'h1230_0001); wreg(10, 32'h0010_0000); wreg(11, 32'h3);
    wreg(2, 32'h0);
    req(40'h00_1230_0100, 0, "R7 lowest range wins");
    wreg(0, 32'h1230_0000);
    req(40'h00_1230_0100, 1, "R2 disabled range yields");
    wreg(12, 32'hFFFF_FFFF); wreg(15, 32'h0000_0001);
    req(40'h00_1230_0100, 0, "R1 out-of-range index ignored");
    req(40'h00_F800_0000, 0, "R1 range1 intact");
    @(negedge clk); req_valid = 1; req_addr = 40'h00_7000_0004; win_hit = 0;
    wr_en = 1; wr_idx = 4'd8; wr_data = 32'h1;
    expq.push_back(model(40'h00_7000_0004, 0)); tagq.push_back("R1 write next cycle");
    sr[2] = 32'h1;
    @(posedge clk); #1 req_valid = 0; wr_en = 0;
    req(40'h00_7000_0004, 0, "R1 write applied");
    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin errors++; $display("FAIL R9 missing results act=%0d exp=0", expq.size()); end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule